// File: doc/BRIEF.md
# Triggered DMA Request Generator Bank

This block holds four independent generators that turn trigger events into bursts of DMA requests. Software programs each generator through a small word-addressed register port. It picks one of 32 trigger lines, sets a burst length, and arms the generator. A rising edge on the chosen line then starts a burst. During the burst the generator drives its request line toward the DMA controller until the programmed number of requests has been accepted.

Each request line follows valid/ready rules. `dma_req[g]` is the valid and `dma_ack[g]` is the ready. One request is accepted on each clock edge where both are high. While ack is low, req stays high and unchanged, so the controller can apply back-pressure for as long as it needs. If the selected trigger rises again before the burst is complete, the generator does not restart. Instead it sets a sticky overrun flag. That flag can raise a per-generator interrupt and is cleared through a separate write-1-to-clear register.

Top module: `dma_reqgen_bank`

## Requirements
- R1: After reset, all control words, the status word and the clear word read 0, and `dma_req` and `irq` are all 0.
- R2: Control word g is at word address g (g = 0..3). It holds select in bits 4:0, interrupt enable in bit 8, burst count in bits 20:16 and arm in bit 24. While arm is 0, the generator issues no requests and ignores its trigger, so no overrun flag is set.
- R3: Only the trigger line `trig_in[select]` can start a burst. Edges on other lines have no effect.
- R4: Suppose the selected line is low at one clock edge and high at the next while the generator is idle. Then `dma_req[g]` is high after that second edge. A line held high launches only one burst.
- R5: A burst ends after exactly count+1 accepted requests (edges with req and ack both high). While ack is low, req stays high.
- R6: A rising edge on the selected line while a burst is in progress sets status bit g (word address 4, bits 3:0). It does not restart or lengthen the burst.
- R7: A rising edge after a burst has completed starts a new full burst and sets no flag.
- R8: `irq[g]` is high exactly when status bit g and the interrupt enable of generator g are both 1.
- R9: Writing word address 5 with bit g set clears status bit g. Writing 0 to a bit leaves that flag unchanged. Word 5 reads as 0.
- R10: If an overrun and a clear of the same flag happen on the same edge, the flag ends up set.
- R11: Reserved control bits read 0 whatever was written. Writes to the status word are ignored. Unmapped addresses (6, 7) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| trig_in | input | 32 | Trigger lines |
| dma_req | output | 4 | Per-generator request (valid) |
| dma_ack | input | 4 | Per-generator acknowledge (ready) |
| irq | output | 4 | Per-generator overrun interrupt |

## Verification
Register writes take effect at the edge that samples `reg_wr`, and read data is combinational. Request lines rise right after the edge that first sees the selected trigger high. An overrun flag, and with it `irq`, is visible right after the edge that sees the second rising trigger. The bench drives every input at the falling edge and samples each result at the next falling edge after the edge where it is due. A scoreboard compares each finished burst's accepted-request count with the length pushed when the trigger was driven. It counts requests on rising edges and detects burst ends on falling edges.

// File: rtl/dma_reqgen_pkg.sv
package dma_reqgen_pkg;
  localparam int CTRL_SEL_LSB = 0;
  localparam int CTRL_IE_BIT  = 8;
  localparam int CTRL_CNT_LSB = 16;
  localparam int CTRL_EN_BIT  = 24;
endpackage

// File: rtl/dma_reqgen_regs.sv
module dma_reqgen_regs
  import dma_reqgen_pkg::*;
#(
  parameter int NG     = 4,
  parameter int SEL_W  = 5,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NG-1:0]              ovr_set,
  output logic [NG-1:0][SEL_W-1:0]   sel_o,
  output logic [NG-1:0][CNT_W-1:0]   cnt_o,
  output logic [NG-1:0]              en_o,
  output logic [NG-1:0]              irq
);
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(NG);
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = ADDR_W'(NG + 1);

  logic [NG-1:0][SEL_W-1:0] sel_q;
  logic [NG-1:0][CNT_W-1:0] cnt_q;
  logic [NG-1:0]            ie_q, en_q, flag_q;
  logic                     clr_hit;
  logic [NG-1:0]            clr_mask;

  assign clr_hit  = reg_wr && (reg_addr == ADDR_CLEAR);
  assign clr_mask = clr_hit ? reg_wdata[NG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cnt_q  <= '0;
      ie_q   <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (reg_wr && reg_addr == ADDR_W'(g)) begin
          sel_q[g] <= reg_wdata[CTRL_SEL_LSB +: SEL_W];
          cnt_q[g] <= reg_wdata[CTRL_CNT_LSB +: CNT_W];
          ie_q[g]  <= reg_wdata[CTRL_IE_BIT];
          en_q[g]  <= reg_wdata[CTRL_EN_BIT];
        end
      end
      flag_q <= ovr_set | (flag_q & ~clr_mask);
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NG; g++) begin
      if (reg_addr == ADDR_W'(g)) begin
        reg_rdata[CTRL_SEL_LSB +: SEL_W] = sel_q[g];
        reg_rdata[CTRL_CNT_LSB +: CNT_W] = cnt_q[g];
        reg_rdata[CTRL_IE_BIT]           = ie_q[g];
        reg_rdata[CTRL_EN_BIT]           = en_q[g];
      end
    end
    if (reg_addr == ADDR_STATUS) reg_rdata[NG-1:0] = flag_q;
  end

  assign sel_o = sel_q;
  assign cnt_o = cnt_q;
  assign en_o  = en_q;
  assign irq   = flag_q & ie_q;

  for (genvar g = 0; g < NG; g++) begin : g_chk
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_set[g] |=> flag_q[g]);
    a_r9_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && reg_wdata[g] && !ovr_set[g]) |=> !flag_q[g]);
    a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !(clr_hit && reg_wdata[g])) |=> flag_q[g]);
  end
endmodule

// File: rtl/dma_reqgen_unit.sv
module dma_reqgen_unit #(
  parameter int NT    = 32,
  parameter int SEL_W = 5,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [NT-1:0]    trig,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ack,
  output logic             req,
  output logic             ovr
);
  localparam int REM_W = CNT_W + 1;

  logic             picked, prev_q, edge_det, busy, fire;
  logic [REM_W-1:0] remaining;

  assign picked   = trig[sel];
  assign edge_det = picked & ~prev_q;
  assign busy     = (remaining != '0);
  assign req      = en & busy;
  assign fire     = req & ack;
  assign ovr      = en & edge_det & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      remaining <= '0;
    end else begin
      prev_q <= picked;
      if (!en)
        remaining <= '0;
      else if (edge_det && !busy)
        remaining <= REM_W'(cnt) + 1'b1;
      else if (fire)
        remaining <= remaining - 1'b1;
    end
  end

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req || !en));
  a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_det && !busy) |=> (req || !en));
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> (remaining <= $past(remaining)));
  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (remaining == $past(remaining) - 1'b1 || !en));
endmodule

// File: rtl/dma_reqgen_bank.sv
module dma_reqgen_bank #(
  parameter int NUM_GEN  = 4,
  parameter int NUM_TRIG = 32,
  parameter int CNT_W    = 5,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic [NUM_GEN-1:0]  dma_req,
  input  logic [NUM_GEN-1:0]  dma_ack,
  output logic [NUM_GEN-1:0]  irq
);
  localparam int SEL_W = $clog2(NUM_TRIG);

  logic [NUM_GEN-1:0][SEL_W-1:0] sel;
  logic [NUM_GEN-1:0][CNT_W-1:0] cnt;
  logic [NUM_GEN-1:0]            en, ovr;

  dma_reqgen_regs #(
    .NG(NUM_GEN), .SEL_W(SEL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovr_set(ovr),
    .sel_o(sel), .cnt_o(cnt), .en_o(en), .irq(irq)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_unit
    dma_reqgen_unit #(.NT(NUM_TRIG), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_unit (
      .clk(clk), .rst_n(rst_n), .en(en[g]), .sel(sel[g]), .trig(trig_in),
      .cnt(cnt[g]), .ack(dma_ack[g]), .req(dma_req[g]), .ovr(ovr[g])
    );
    a_r2_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en[g] |-> (!dma_req[g] && !ovr[g]));
  end
endmodule

// File: tb/tb_dma_reqgen_bank.sv
module tb_dma_reqgen_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] trig_in = 0;
  logic [3:0]  dma_req;
  logic [3:0]  dma_ack = 4'hF;
  logic [3:0]  irq;

  logic [3:0]  ack_hold = 0, rnd_mask = 0, req_seen = 0;
  logic [7:0]  lfsr = 8'h5A;
  int          beats[4], base[4];
  int          exp_g[$], exp_n[$];
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_reqgen_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq)
  );

  function automatic logic [31:0] ctrl(int sel, int cnt, bit ie, bit en);
    return 32'(sel) | (32'(ie) << 8) | (32'(cnt) << 16) | (32'(en) << 24);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    for (int g = 0; g < 4; g++)
      dma_ack[g] <= ack_hold[g] ? 1'b0 : (rnd_mask[g] ? lfsr[g] : 1'b1);
  end

  always @(posedge clk)
    for (int g = 0; g < 4; g++)
      if (dma_req[g] && dma_ack[g]) beats[g]++;

  always @(negedge clk) begin
    for (int g = 0; g < 4; g++) begin
      if (req_seen[g] && !dma_req[g]) begin
        if (exp_g.size() == 0) begin
          check("R5 unexpected burst end", 32'(g), 32'hFFFF);
        end else begin
          int eg, en_;
          eg = exp_g.pop_front();
          en_ = exp_n.pop_front();
          check("R5/R6 burst generator", 32'(g), 32'(eg));
          check("R5/R6 burst length", 32'(beats[g] - base[g]), 32'(en_));
        end
        base[g] = beats[g];
      end
    end
    req_seen = dma_req;
  end

  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 3'(a); #1; d = reg_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int line);
    trig_in[line] = 1; cyc(2); trig_in[line] = 0; cyc(1);
  endtask

  task automatic expect_burst(int g, int cnt);
    exp_g.push_back(g); exp_n.push_back(cnt + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(a, d); check("R1 reset reg", d, 0); end
    check("R1 reset req", 32'(dma_req), 0);
    check("R1 reset irq", 32'(irq), 0);

    // R11 reserved bits, status write, unmapped
    wr(1, 32'hFFFF_FFFF); rd(1, d); check("R11 reserved bits", d, 32'h011F_011F);
    wr(1, 0);
    wr(4, 32'hF); rd(4, d); check("R11 status write ignored", d, 0);
    rd(6, d); check("R11 unmapped 6", d, 0);
    rd(7, d); check("R11 unmapped 7", d, 0);
    rd(5, d); check("R9 clear reads zero", d, 0);

    // R2 disarmed
    wr(0, ctrl(3, 2, 0, 0));
    pulse(3); cyc(4);
    check("R2 disarmed no req", 32'(dma_req), 0);
    rd(4, d); check("R2 disarmed no flag", d, 0);

    // R3, R4: other line ignored, edge launch, level held gives one burst
    wr(0, ctrl(3, 2, 0, 1));
    pulse(5); cyc(3);
    check("R3 other line ignored", 32'(dma_req[0]), 0);
    expect_burst(0, 2);
    trig_in[3] = 1; @(posedge clk); @(negedge clk);
    check("R4 req after edge", 32'(dma_req[0]), 1);
    cyc(10); trig_in[3] = 0; cyc(2);
    check("R4 level one burst", 32'(exp_g.size()), 0);

    // R5 back-pressure on generator 1
    ack_hold[1] = 1; cyc(1);
    wr(1, ctrl(7, 4, 0, 1));
    expect_burst(1, 4);
    pulse(7); cyc(5);
    check("R5 req held under back-pressure", 32'(dma_req[1]), 1);
    ack_hold[1] = 0; rnd_mask[1] = 1;
    cyc(40); rnd_mask[1] = 0; cyc(2);
    check("R5 burst done", 32'(dma_req[1]), 0);

    // R6 overrun, R8 interrupt gating
    ack_hold[2] = 1; cyc(1);
    wr(2, ctrl(10, 7, 0, 1));
    expect_burst(2, 7);
    pulse(10); cyc(1);
    pulse(10);
    rd(4, d); check("R6 overrun flag", d, 32'h4);
    check("R8 irq masked", 32'(irq), 0);
    wr(2, ctrl(10, 7, 1, 1));
    check("R8 irq enabled", 32'(irq), 32'h4);
    ack_hold[2] = 0; cyc(15);

    // R9 clear rules
    wr(5, 32'h0); rd(4, d); check("R9 zero write keeps", d, 32'h4);
    wr(5, 32'h4); rd(4, d); check("R9 one write clears", d, 0);
    check("R8 irq after clear", 32'(irq), 0);

    // R7 trigger when idle starts a fresh burst
    expect_burst(2, 7);
    pulse(10); cyc(15);
    rd(4, d); check("R7 idle trigger no flag", d, 0);

    // R10 set wins over same-cycle clear
    ack_hold[3] = 1; cyc(1);
    wr(3, ctrl(0, 5, 0, 1));
    expect_burst(3, 5);
    pulse(0); cyc(1);
    trig_in[0] = 1; reg_wr = 1; reg_addr = 5; reg_wdata = 32'h8;
    @(posedge clk); @(negedge clk);
    reg_wr = 0; trig_in[0] = 0;
    rd(4, d); check("R10 set wins", d, 32'h8);
    wr(5, 32'h8); rd(4, d); check("R10 later clear", d, 0);
    ack_hold[3] = 0; cyc(20);

    check("R5 all bursts seen", 32'(exp_g.size()), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule